// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a cycle-level model of the write-command front end of a word-wide NOR-style flash. It watches single-cycle bus writes (address, data, write strobe) and decodes the multi-cycle unlock-based command sequences. Those sequences program a word, enter and leave a fast-program bypass mode, and select or deselect a read-only secured region that holds an eight-word serial number. The block keeps a small internal word array. The array's erased value is all ones, and a program can only clear bits.

A program does not write the array at once. It starts an embedded-program interval, and the `busy` output is high for a fixed number of clocks. The target word takes its new value when that interval ends. While `busy` is high, every bus write is dropped. Reads are combinational from the bus address. They return array words, or serial-number words while the secured region is selected.

All command codes are compared on the low byte of the data bus. Unlock addresses are compared on the low 12 address bits: 555h is the first unlock address and 2AAh is the second. Array words are indexed by the low log2(WORDS) address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `busy`, `bypass_mode` and `secure_mode` are 0, and every array word reads all ones.
- R2: In read mode, the writes AAh@555h, 55h@2AAh and A0h@555h, followed by a write of data D to address A, program word A[idx] to old AND D.
- R3: A program never changes a 0 bit to 1. Programming a word that holds 0F0Fh with F0FFh leaves 000Fh.
- R4: Any write that does not match the next expected cycle of a sequence returns the decoder to read mode. The writes that follow are then not taken as part of the broken sequence, so no program starts and no word changes.
- R5: AAh@555h, 55h@2AAh, 20h@555h sets `bypass_mode`. In bypass mode, A0h at any address followed by address/data programs one word, and this may be repeated with no unlock cycles.
- R6: In bypass mode, only A0h (program) and 90h (reset) are recognised. Other writes, including full unlock sequences, are ignored. 90h followed by 00h clears `bypass_mode`. 90h followed by any other value leaves bypass mode set.
- R7: AAh@555h, 55h@2AAh, 88h@555h sets `secure_mode`. While it is set, reads return SERIAL_BASE XOR A[2:0]. In this mode, a third cycle of 20h or A0h aborts, so bypass mode and programs cannot be reached.
- R8: In secure mode, AAh@555h, 55h@2AAh, 90h@555h, then 00h at any address clears `secure_mode`, and reads return array data again.
- R9: `busy` rises in the cycle after the address/data write and stays high for exactly PROG_CYCLES cycles. Reads during that time return the old word. The new word is visible once `busy` is low.
- R10: Every write made while `busy` is high is ignored. After the interval ends, the decoder is in read mode with its mode flags unchanged.
- R11: Asserting reset during a program drops `busy` at once, discards the pending word, clears both mode flags, and leaves the block ready for a new sequence after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Word address for writes and reads |
| bus_wdata | input | DATA_W | Write data; commands in the low byte |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| busy | output | 1 | Embedded program interval in progress |
| bypass_mode | output | 1 | Unlock bypass mode active |
| secure_mode | output | 1 | Secured serial-number region selected |

## Verification
A wrong sequencer state shows up in one of two ways. Either a mode flag changes on the write that completes a sequence, or it fails to change there. Either way the error can be seen in the cycle after that write. A sequencer left silently in a half-unlocked state shows up later. A following stray write then starts a program, and `busy` rises one cycle after it, while the array word changes PROG_CYCLES cycles after that. A wrong AND merge, a wrong word index, or a commit at the wrong time all show up on `bus_rdata` as soon as `busy` falls. A wrong serial word or a stuck overlay shows up on the very next read while `secure_mode` is set or cleared.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_UNL1,
      ST_UNL2,
      ST_PGM,
      ST_SEC_EXIT,
      ST_BYP_RST
   } seq_state_t;

   localparam int unsigned CMD_ADDR_BITS = 12;

   localparam logic [CMD_ADDR_BITS-1:0] UNLOCK_ADDR_1 = 12'h555;
   localparam logic [CMD_ADDR_BITS-1:0] UNLOCK_ADDR_2 = 12'h2AA;

   localparam logic [7:0] CODE_UNLOCK_1 = 8'hAA;
   localparam logic [7:0] CODE_UNLOCK_2 = 8'h55;
   localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
   localparam logic [7:0] CODE_BYPASS   = 8'h20;
   localparam logic [7:0] CODE_SECURE   = 8'h88;
   localparam logic [7:0] CODE_LEAVE    = 8'h90;
   localparam logic [7:0] CODE_CONFIRM  = 8'h00;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              busy_i,
   output logic              pgm_start_o,
   output logic              bypass_o,
   output logic              secure_o
);

   seq_state_t st_q, st_d;
   logic       byp_q, byp_d;
   logic       sec_q, sec_d;
   logic       take;
   logic       at_first, at_second;
   logic [7:0] code;

   assign take      = we_i && !busy_i;
   assign code      = data_i[7:0];
   assign at_first  = (addr_i[CMD_ADDR_BITS-1:0] == UNLOCK_ADDR_1);
   assign at_second = (addr_i[CMD_ADDR_BITS-1:0] == UNLOCK_ADDR_2);

   always_comb begin
      st_d        = st_q;
      byp_d       = byp_q;
      sec_d       = sec_q;
      pgm_start_o = 1'b0;
      if (take) begin
         unique case (st_q)
            ST_READ: begin
               if (byp_q) begin
                  if (code == CODE_PROGRAM)    st_d = ST_PGM;
                  else if (code == CODE_LEAVE) st_d = ST_BYP_RST;
               end else if (at_first && code == CODE_UNLOCK_1) begin
                  st_d = ST_UNL1;
               end
            end
            ST_UNL1: begin
               st_d = (at_second && code == CODE_UNLOCK_2) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
               st_d = ST_READ;
               if (at_first) begin
                  if (!sec_q) begin
                     if (code == CODE_PROGRAM)     st_d  = ST_PGM;
                     else if (code == CODE_BYPASS) byp_d = 1'b1;
                     else if (code == CODE_SECURE) sec_d = 1'b1;
                  end else if (code == CODE_LEAVE) begin
                     st_d = ST_SEC_EXIT;
                  end
               end
            end
            ST_PGM: begin
               pgm_start_o = 1'b1;
               st_d        = ST_READ;
            end
            ST_SEC_EXIT: begin
               st_d = ST_READ;
               if (code == CODE_CONFIRM) sec_d = 1'b0;
            end
            ST_BYP_RST: begin
               st_d = ST_READ;
               if (code == CODE_CONFIRM) byp_d = 1'b0;
            end
            default: st_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_READ;
         byp_q <= 1'b0;
         sec_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         byp_q <= byp_d;
         sec_q <= sec_d;
      end
   end

   assign bypass_o = byp_q;
   assign secure_o = sec_q;

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable({st_q, byp_q, sec_q})); // R10
   AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(byp_q && sec_q)); // R7
   AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(byp_q) |-> $past(st_q) == ST_UNL2); // R5
   AST_SECURE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sec_q) |-> $past(st_q) == ST_SEC_EXIT); // R8

endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned PROG_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic              commit_o,
   output logic [IDX_W-1:0]  cidx_o,
   output logic [DATA_W-1:0] cdata_o
);

   localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         idx_q  <= '0;
         data_q <= '0;
      end else if (start_i) begin
         cnt_q  <= CNT_LOAD;
         idx_q  <= idx_i;
         data_q <= data_i;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - CNT_LAST;
      end
   end

   assign busy_o   = (cnt_q != '0);
   assign commit_o = (cnt_q == CNT_LAST);
   assign cidx_o   = idx_q;
   assign cdata_o  = data_q;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o); // R10
   AST_FULL_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> cnt_q == CNT_LOAD); // R9
   AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !busy_o); // R9

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned WORDS        = 16,
   parameter int unsigned SERIAL_WORDS = 8,
   parameter logic [DATA_W-1:0] SERIAL_BASE = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [$clog2(WORDS)-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0]         wr_data_i,
   input  logic [ADDR_W-1:0]         rd_addr_i,
   input  logic                      secure_i,
   output logic [DATA_W-1:0]         rd_data_o
);

   localparam int unsigned IDX_W = $clog2(WORDS);
   localparam int unsigned SER_W = $clog2(SERIAL_WORDS);

   logic [DATA_W-1:0] mem_q  [WORDS];
   logic [DATA_W-1:0] serial [SERIAL_WORDS];

   for (genvar gi = 0; gi < SERIAL_WORDS; gi++) begin : g_serial
      assign serial[gi] = SERIAL_BASE ^ DATA_W'(gi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      end else if (wr_en_i) begin
         mem_q[wr_idx_i] <= mem_q[wr_idx_i] & wr_data_i;
      end
   end

   assign rd_data_o = secure_i ? serial[rd_addr_i[SER_W-1:0]]
                               : mem_q[rd_addr_i[IDX_W-1:0]];

   AST_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (mem_q[$past(wr_idx_i)] & ~$past(mem_q[wr_idx_i])) == '0); // R3
   AST_CLEARS_DATA_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (mem_q[$past(wr_idx_i)] & ~$past(wr_data_i)) == '0); // R2

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned WORDS        = 16,
   parameter int unsigned SERIAL_WORDS = 8,
   parameter int unsigned PROG_CYCLES  = 8,
   parameter logic [DATA_W-1:0] SERIAL_BASE = DATA_W'(16'h5EC0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              bypass_mode,
   output logic              secure_mode
);

   localparam int unsigned IDX_W = $clog2(WORDS);

   if (ADDR_W < CMD_ADDR_BITS) begin : g_bad_addr
      $error("ADDR_W must cover the 12-bit unlock addresses");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit command code");
   end
   if (WORDS < 2 || (1 << IDX_W) != WORDS || IDX_W > ADDR_W) begin : g_bad_words
      $error("WORDS must be a power of two addressable by ADDR_W");
   end
   if (SERIAL_WORDS < 2 || (1 << $clog2(SERIAL_WORDS)) != SERIAL_WORDS) begin : g_bad_serial
      $error("SERIAL_WORDS must be a power of two");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least one");
   end

   logic              pgm_start;
   logic              commit;
   logic [IDX_W-1:0]  commit_idx;
   logic [DATA_W-1:0] commit_data;

   flash_cmd_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (bus_we),
      .addr_i      (bus_addr),
      .data_i      (bus_wdata),
      .busy_i      (busy),
      .pgm_start_o (pgm_start),
      .bypass_o    (bypass_mode),
      .secure_o    (secure_mode)
   );

   flash_prog_timer #(
      .IDX_W       (IDX_W),
      .DATA_W      (DATA_W),
      .PROG_CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (pgm_start),
      .idx_i    (bus_addr[IDX_W-1:0]),
      .data_i   (bus_wdata),
      .busy_o   (busy),
      .commit_o (commit),
      .cidx_o   (commit_idx),
      .cdata_o  (commit_data)
   );

   flash_word_array #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .WORDS        (WORDS),
      .SERIAL_WORDS (SERIAL_WORDS),
      .SERIAL_BASE  (SERIAL_BASE)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (commit),
      .wr_idx_i  (commit_idx),
      .wr_data_i (commit_data),
      .rd_addr_i (bus_addr),
      .secure_i  (secure_mode),
      .rd_data_o (bus_rdata)
   );

   AST_NO_PGM_IN_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_start |-> !secure_mode); // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !busy && !bypass_mode && !secure_mode); // R1

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

   localparam int unsigned PROG = 8;
   localparam logic [15:0] SER  = 16'h5EC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        busy, bypass_mode, secure_mode;

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl [16];
   logic        mbyp = 1'b0;

   always #5 clk = ~clk;

   flash_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
      .bypass_mode(bypass_mode), .secure_mode(secure_mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic unl();
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0055);
   endtask

   function automatic logic [15:0] merged(input logic [15:0] old, input logic [15:0] d);
      return old & d;
   endfunction

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic finish_pgm(input logic [15:0] a, input logic [15:0] d);
      int n = 0;
      #1;
      check("R9 read old during busy", bus_rdata, mdl[a[3:0]]);
      while (busy) begin
         n++;
         @(negedge clk);
         #1;
      end
      check("R9 busy length", n, PROG);
      mdl[a[3:0]] = merged(mdl[a[3:0]], d);
      rd_chk("R2 programmed word", a, mdl[a[3:0]]);
   endtask

   task automatic std_prog(input logic [15:0] a, input logic [15:0] d);
      unl();
      wr(16'h0555, 16'h00A0);
      wr(a, d);
      finish_pgm(a, d);
   endtask

   task automatic byp_prog(input logic [15:0] a, input logic [15:0] d);
      wr(16'h0ABC, 16'h00A0);
      wr(a, d);
      finish_pgm(a, d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) mdl[i] = 16'hFFFF;
      mbyp = 1'b0;
      #1;
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      void'($urandom(32'd2718));
      do_reset();
      repeat (3) @(negedge clk);
      check("R1 busy reset", busy, 0);
      check("R1 bypass reset", bypass_mode, 0);
      check("R1 secure reset", secure_mode, 0);
      for (int i = 0; i < 16; i++) rd_chk("R1 erased word", 16'(i), 16'hFFFF);
      rst_n = 1'b1;

      // R2 / R9: standard program
      std_prog(16'h0003, 16'h0F0F);
      check("R2 word3", mdl[3], 16'h0F0F);
      // R3: zeros stay zero
      std_prog(16'h0003, 16'hF0FF);
      rd_chk("R3 no 0-to-1", 16'h0003, 16'h000F);

      // R4: aborted sequences
      unl();
      wr(16'h0555, 16'h0077);
      wr(16'h0003, 16'h0000);
      #1;
      check("R4 no busy after abort", busy, 0);
      rd_chk("R4 word unchanged", 16'h0003, 16'h000F);
      wr(16'h0555, 16'h00AA);
      wr(16'h02AA, 16'h0056);
      wr(16'h0555, 16'h00A0);
      wr(16'h0004, 16'h0000);
      #1;
      check("R4 no busy after bad second cycle", busy, 0);
      rd_chk("R4 word4 unchanged", 16'h0004, 16'hFFFF);

      // R10: writes during busy ignored
      unl();
      wr(16'h0555, 16'h00A0);
      wr(16'h0006, 16'h1234);
      unl();
      wr(16'h0555, 16'h0020);
      while (busy) @(negedge clk);
      mdl[6] = merged(mdl[6], 16'h1234);
      #1;
      check("R10 bypass not entered while busy", bypass_mode, 0);
      rd_chk("R10 program still completed", 16'h0006, 16'h1234);

      // R5: bypass mode
      unl();
      wr(16'h0555, 16'h0020);
      #1;
      check("R5 bypass set", bypass_mode, 1);
      byp_prog(16'h0007, 16'hABCD);
      byp_prog(16'h0F08, 16'h5A5A);
      check("R5 still bypass", bypass_mode, 1);

      // R6: only A0/90 recognised in bypass
      unl();
      wr(16'h0555, 16'h0088);
      #1;
      check("R6 secure ignored in bypass", secure_mode, 0);
      wr(16'h0000, 16'h0090);
      wr(16'h0000, 16'h0011);
      #1;
      check("R6 bypass kept on bad confirm", bypass_mode, 1);
      wr(16'h0000, 16'h0090);
      wr(16'h0000, 16'h0000);
      #1;
      check("R6 bypass cleared", bypass_mode, 0);

      // R7: secure overlay
      unl();
      wr(16'h0555, 16'h0088);
      #1;
      check("R7 secure set", secure_mode, 1);
      rd_chk("R7 serial word 2", 16'h0002, SER ^ 16'd2);
      rd_chk("R7 serial word 7", 16'h001F, SER ^ 16'd7);
      unl();
      wr(16'h0555, 16'h0020);
      #1;
      check("R7 no bypass in secure", bypass_mode, 0);
      unl();
      wr(16'h0555, 16'h00A0);
      wr(16'h0005, 16'h0000);
      #1;
      check("R7 no program in secure", busy, 0);

      // R8: secure exit
      unl();
      wr(16'h0555, 16'h0090);
      wr(16'h0123, 16'h0000);
      #1;
      check("R8 secure cleared", secure_mode, 0);
      rd_chk("R8 array visible", 16'h0003, 16'h000F);
      rd_chk("R8 word5 untouched", 16'h0005, 16'hFFFF);

      // R11: reset mid-program
      unl();
      wr(16'h0555, 16'h0020);
      wr(16'h0000, 16'h00A0);
      wr(16'h0009, 16'h0000);
      @(negedge clk);
      do_reset();
      check("R11 busy dropped", busy, 0);
      check("R11 bypass cleared", bypass_mode, 0);
      rd_chk("R11 pending word discarded", 16'h0009, 16'hFFFF);
      @(negedge clk);
      rst_n = 1'b1;
      std_prog(16'h0009, 16'h00F0);
      rd_chk("R11 new program after reset", 16'h0009, 16'h00F0);

      // Random mix against bench model
      for (int it = 0; it < 40; it++) begin
         logic [15:0] a = 16'($urandom);
         logic [15:0] d = 16'($urandom);
         int sel = int'($urandom % 4);
         if (sel == 0) begin
            if (mbyp) wr(16'h0555, 16'h00AA);
            else begin unl(); wr(16'h0555, 16'h0033); end
            wr(a, d);
            #1;
            check("R4 random abort no busy", busy, 0);
         end else if (sel == 1) begin
            if (mbyp) begin
               wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000); mbyp = 1'b0;
            end
            std_prog(a, d);
         end else begin
            if (!mbyp) begin
               unl(); wr(16'h0555, 16'h0020); mbyp = 1'b1;
            end
            byp_prog(a, d);
         end
         #1;
         check("R5 random mode flag", bypass_mode, mbyp);
      end
      for (int i = 0; i < 16; i++) rd_chk("R2 random final word", 16'(i), mdl[i]);

      report();
   end

endmodule